// File: doc/BRIEF.md
# Radix-4 Booth Significand Multiplier

This block forms the exact product of two unsigned 53-bit significands, hidden bit included, and returns all 106 bits. It is meant as the multiply stage in front of the addend alignment of a double-precision fused multiply-add unit. The exponent path, alignment, normalization and rounding sit elsewhere.

The multiplier operand gets one zero bit above its top bit and is recoded into 27 radix-4 Booth digits. Each digit drives a five-way selector that picks 0, +M, -M, +2M or -2M of the multiplicand. A negative choice is the one's complement of the magnitude, and a separate row carries a +1 correction at the row's lowest bit. The rows use a compact sign extension: one inverted sign bit under a short run of constant ones. A carry-save tree of 4:2 compressors reduces them to a sum vector and a carry vector. Each compressor is two chained 3:2 adders, and a carry passes sideways to the next bit. One carry-propagate adder then resolves the two vectors.

The result can leave combinationally, or through one output register with a valid flag. The register is on by default.

Top module: `booth_sig_mult`

## Requirements
- R1: For any two 53-bit unsigned operands, the 106-bit product equals their exact integer product. Any carry above bit 105 is dropped.
- R2: The multiplier is recoded into 27 radix-4 digits. Each digit comes from the triplet (bit 2i+1, bit 2i, bit 2i-1), with bit -1 taken as zero and bit 53 taken as zero. Operands with alternating bit patterns, which produce every digit value from -2 to +2, still give the exact product.
- R3: Negative partial products (digits -1 and -2) are formed as one's complement plus a correction bit. Multipliers made mostly of negative digits give the exact product.
- R4: When either operand is zero, the product is exactly zero.
- R5: When both operands are all ones, the product equals (2^53-1)^2, which is 52 ones, then 53 zeros, then a single one.
- R6: With the output register on, out_valid is high in exactly the cycle after a cycle with in_valid high. The product shown then belongs to the operands captured at that edge. Operations issued back to back each appear one cycle later.
- R7: The synchronous active-high reset clears out_valid. If reset and in_valid are high in the same cycle, out_valid stays low in the next cycle.
- R8: While in_valid is low, the registered product holds its value even if the operand inputs change.
- R9: An operand with a single set bit at position k gives the other operand shifted left by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears out_valid |
| in_valid | input | 1 | Operands on a_sig and b_sig are to be captured |
| a_sig | input | 53 | Multiplicand significand, hidden bit included |
| b_sig | input | 53 | Multiplier significand, hidden bit included (Booth-recoded) |
| out_valid | output | 1 | Product holds a result captured in the previous cycle |
| product | output | 106 | Full unsigned product |

## Verification
Two things can happen at the same clock edge: a new operand capture and a synchronous reset. The bench drives reset and in_valid high together with non-zero operands. It then expects out_valid low on the next cycle and again after reset is released, and then a normal capture afterwards. The other overlap is a new capture in the same cycle that the previous result is shown. A back-to-back stream, checked against a shift-and-add model in the bench, shows that each result matches the operands from exactly one edge earlier.

// File: rtl/smul_pkg.sv
package smul_pkg;

  localparam int unsigned SIG_W = 53;

  // One Booth digit: magnitude one, magnitude two, negate
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  // Decode the triplet {upper, centre, lower} into a signed radix-4 digit
  function automatic bdig_t booth_decode(input logic [2:0] t);
    bdig_t d;
    d.one = t[1] ^ t[0];
    d.two = (t[2] & ~t[1] & ~t[0]) | (~t[2] & t[1] & t[0]);
    d.neg = t[2] & ~(t[1] & t[0]);
    return d;
  endfunction

endpackage

// File: rtl/smul_csa32.sv
module smul_csa32 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] co
);
  // bitwise full adders, carry kept at the same weight (caller shifts it)
  assign s  = a ^ b ^ c;
  assign co = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/smul_csa42.sv
module smul_csa42 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] s_mid, c_mid, side_in, c_out;

  // first 3:2 stage
  smul_csa32 #(.W(W)) u_lo (
    .a(x0), .b(x1), .c(x2), .s(s_mid), .co(c_mid)
  );

  // intermediate carry travels sideways into the next bit position
  assign side_in = c_mid << 1;

  // second 3:2 stage
  smul_csa32 #(.W(W)) u_hi (
    .a(s_mid), .b(x3), .c(side_in), .s(sum), .co(c_out)
  );

  assign carry = c_out << 1;
endmodule

// File: rtl/smul_pp_gen.sv
module smul_pp_gen
  import smul_pkg::*;
#(
  parameter int unsigned W  = 53,
  parameter int unsigned ND = W / 2 + 1,
  parameter int unsigned NR = ND + 1,
  parameter int unsigned P  = 2 * W
) (
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [P-1:0] rows [NR]
);
  localparam int unsigned EW = 2 * ND + 1;
  localparam int unsigned XW = P + W + 8;

  logic [EW-1:0] mext;
  bdig_t         digs [ND];
  logic [P-1:0]  corr;

  // zero bit below bit 0, zero padding above the top bit
  assign mext = {{(EW - W - 1){1'b0}}, mplier, 1'b0};

  // five-way selector plus compact sign extension, placed at weight 4^idx
  function automatic logic [P-1:0] form_row(input logic [W-1:0] m,
                                            input bdig_t d,
                                            input int unsigned idx);
    logic [W:0]   mag;
    logic [W:0]   bits;
    logic [W+3:0] ext;
    logic [XW-1:0] wide;
    unique case ({d.two, d.one})
      2'b10:   mag = {m, 1'b0};
      2'b01:   mag = {1'b0, m};
      default: mag = '0;
    endcase
    bits = d.neg ? ~mag : mag;
    if (idx == 0) ext = {~d.neg, d.neg, d.neg, bits};
    else          ext = {1'b0, 1'b1, ~d.neg, bits};
    wide = '0;
    wide[W+3:0] = ext;
    wide = wide << (2 * idx);
    return wide[P-1:0];
  endfunction

  for (genvar i = 0; i < ND; i++) begin : g_dig
    assign digs[i] = booth_decode(mext[2*i+2 -: 3]);
    assign rows[i] = form_row(mcand, digs[i], i);
  end

  // +1 corrections for negated rows, each at its row's lowest bit
  always_comb begin
    corr = '0;
    for (int i = 0; i < ND; i++) corr[2*i] = digs[i].neg;
  end
  assign rows[ND] = corr;

endmodule

// File: rtl/smul_tree.sv
module smul_tree #(
  parameter int unsigned P  = 106,
  parameter int unsigned NR = 28
) (
  input  logic [P-1:0] rows_i [NR],
  output logic [P-1:0] sum_o,
  output logic [P-1:0] carry_o
);
  localparam int unsigned LV   = $clog2(NR) - 1;
  localparam int unsigned NPAD = 1 << (LV + 1);

  for (genvar k = 0; k <= LV; k++) begin : g_lvl
    localparam int unsigned CNT = NPAD >> k;
    logic [P-1:0] r [CNT];
    if (k == 0) begin : g_in
      for (genvar j = 0; j < NPAD; j++) begin : g_pad
        if (j < NR) begin : g_real
          assign r[j] = rows_i[j];
        end else begin : g_zero
          assign r[j] = '0;
        end
      end
    end else begin : g_red
      for (genvar g = 0; g < CNT / 2; g++) begin : g_cmp
        smul_csa42 #(.W(P)) u_c42 (
          .x0   (g_lvl[k-1].r[4*g]),
          .x1   (g_lvl[k-1].r[4*g+1]),
          .x2   (g_lvl[k-1].r[4*g+2]),
          .x3   (g_lvl[k-1].r[4*g+3]),
          .sum  (r[2*g]),
          .carry(r[2*g+1])
        );
      end
    end
  end

  assign sum_o   = g_lvl[LV].r[0];
  assign carry_o = g_lvl[LV].r[1];
endmodule

// File: rtl/booth_sig_mult.sv
module booth_sig_mult #(
  parameter int unsigned W       = smul_pkg::SIG_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   a_sig,
  input  logic [W-1:0]   b_sig,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int unsigned P  = 2 * W;
  localparam int unsigned ND = W / 2 + 1;
  localparam int unsigned NR = ND + 1;
  localparam logic [P-1:0] FULL_SQ = {{(W-1){1'b1}}, {W{1'b0}}, 1'b1};

  logic [P-1:0] pp_rows [NR];
  logic [P-1:0] tree_sum, tree_carry, prod_comb;

  // named events for the checks
  logic op_zero, op_full, capture;
  assign op_zero = (a_sig == '0) || (b_sig == '0);
  assign op_full = (&a_sig) && (&b_sig);
  assign capture = in_valid && !rst;

  smul_pp_gen #(.W(W), .ND(ND), .NR(NR), .P(P)) u_pp (
    .mcand (a_sig),
    .mplier(b_sig),
    .rows  (pp_rows)
  );

  smul_tree #(.P(P), .NR(NR)) u_tree (
    .rows_i (pp_rows),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  // final carry-propagate adder; overflow past the top bit is dropped
  assign prod_comb = tree_sum + tree_carry;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
      if (in_valid) product <= prod_comb;
    end

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      capture |=> out_valid);
    // R6
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(product));
    // R4
    zero_product_chk: assert property (@(posedge clk) disable iff (rst)
      (capture && op_zero) |=> (product == '0));
    // R5
    full_square_chk: assert property (@(posedge clk) disable iff (rst)
      (capture && op_full) |=> (product == FULL_SQ));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign product   = prod_comb;
  end

endmodule

// File: tb/booth_sig_mult_tb.sv
module booth_sig_mult_tb;
  localparam int unsigned W = 53;
  localparam int unsigned P = 2 * W;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] a_sig, b_sig;
  logic         out_valid;
  logic [P-1:0] product;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  booth_sig_mult u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sig(a_sig), .b_sig(b_sig),
    .out_valid(out_valid), .product(product)
  );

  // shift-and-add reference, independent of recoding
  function automatic logic [P-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [P-1:0] acc = '0;
    for (int i = 0; i < W; i++)
      if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
    return acc;
  endfunction

  task automatic check_val(input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // single operation: drive at a falling edge, read one falling edge later
  task automatic run_op(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a_sig = x; b_sig = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({req, " out_valid"}, out_valid, 1'b1);
    check_val(req, product, ref_mul(x, y));
  endtask

  function automatic logic [W-1:0] rnd_op();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [P-1:0] prev_exp;
    logic [P-1:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; a_sig = '0; b_sig = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R7 reset state", out_valid, 1'b0);

    // R4 zero operands
    run_op("R4 a zero", '0, rnd_op());
    run_op("R4 b zero", rnd_op(), '0);
    run_op("R4 both zero", '0, '0);
    // R5 all ones
    run_op("R5 full", '1, '1);
    check_val("R5 literal", product, {{(W-1){1'b1}}, {W{1'b0}}, 1'b1});
    // R2 alternating patterns covering every digit value
    run_op("R2 0101", '1, {27{2'b01}});
    run_op("R2 1010", '1, {27{2'b10}});
    run_op("R2 0110", rnd_op(), {14{4'b0110}});
    run_op("R2 1001", rnd_op(), {14{4'b1001}});
    run_op("R2 mixed", {27{2'b10}}, {18{3'b011}});
    // R3 negative-heavy multipliers (digit pattern 1x0 / 101 / 110)
    run_op("R3 neg2", rnd_op(), {14{4'b1100}});
    run_op("R3 neg1", rnd_op(), {18{3'b101}});
    run_op("R3 top", '1, {1'b1, {(W-1){1'b0}}} | 53'h5);
    // R9 single-bit operands
    for (int k = 0; k < W; k += 13) begin
      logic [W-1:0] x;
      x = rnd_op();
      run_op("R9 shift", x, 53'd1 << k);
      check_val("R9 literal", product, {{W{1'b0}}, x} << k);
    end

    // R1 random operands
    for (int n = 0; n < 300; n++) run_op("R1 random", rnd_op(), rnd_op());

    // R6 back-to-back stream
    prev_exp = '0;
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] x, y;
      @(negedge clk);
      if (n > 0) begin
        check_bit("R6 stream valid", out_valid, 1'b1);
        check_val("R6 stream", product, prev_exp);
      end
      x = rnd_op(); y = (n % 3 == 0) ? '0 : rnd_op();
      a_sig = x; b_sig = y; in_valid = 1'b1;
      prev_exp = ref_mul(x, y);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R6 stream tail valid", out_valid, 1'b1);
    check_val("R6 stream tail", product, prev_exp);

    // R8 hold while idle with changing operands
    held = product;
    a_sig = rnd_op(); b_sig = rnd_op();
    @(negedge clk);
    check_bit("R8 idle valid", out_valid, 1'b0);
    check_val("R8 hold", product, held);
    a_sig = '1; b_sig = '1;
    @(negedge clk);
    check_val("R8 hold again", product, held);

    // R7 reset and capture in the same cycle
    rst = 1'b1; in_valid = 1'b1; a_sig = rnd_op(); b_sig = rnd_op();
    @(negedge clk);
    check_bit("R7 reset wins", out_valid, 1'b0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check_bit("R7 after reset", out_valid, 1'b0);
    run_op("R7 recovery", rnd_op(), rnd_op());

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule